// File: doc/BRIEF.md
# Booth Multiplier Test Vector Sequencer

This block plays out the complete structural test set for a radix-4 Booth array multiplier whose operand widths are set by parameters. After a single start request it presents one vector per clock for nineteen consecutive cycles. Each vector holds the multiplicand pattern, the extra test input below the multiplicand LSB, the multiplier pattern, the extra test input below the multiplier LSB, and the four test-enable lines of the array. The number of vectors does not depend on the operand widths. Only the length of each pattern changes.

Every vector is kept as an 8-bit base pattern and widened when the block is elaborated. The multiplicand pattern keeps its eight stored bits at the top and gains new bits below them. Those new bits continue its two-bit period toward the LSB. The multiplier pattern keeps its stored bits at the bottom and gains new bits above them. Those new bits repeat the 8-bit base pattern toward the MSB. A consumer, which is normally a multiplier under test plus whatever captures its product, samples the vector in every cycle in which the valid strobe is high. The index output names the vector being shown, and a one-cycle done pulse marks the end of the set.

Top module: `tvec_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears itself. From the next cycle `vec_valid`, `done`, `vec_idx` and every vector output are 0 until a new start is accepted.
- R2: While the block is idle, a high `start` at a rising edge makes `vec_valid` high from the next cycle for exactly 19 consecutive cycles. During those cycles `vec_idx` reads 0, 1, ..., 18, one value per cycle.
- R3: `done` is high for exactly one cycle, namely the cycle right after the one that shows index 18. `vec_valid` is low in that cycle.
- R4: A high `start` while vectors are being shown has no effect: the index sequence and the vector contents continue unchanged. A start that arrives in the `done` cycle is accepted.
- R5: With 8-bit operands, the vector at each index is the following, written as index:X/x-1/Y/y-1/E. X and Y are in hex, and E is the four test lines in the order e4 e3 e2 e1, with e4 as the MSB of `vec_e`. The vectors are 0:00/0/00/0/0, 1:80/0/55/0/0, 2:FF/1/55/0/F, 3:80/0/AA/1/F, 4:00/0/FF/0/C, 5:00/0/33/1/3, 6:FF/1/53/0/3, 7:FF/1/44/1/C, 8:55/0/CC/1/6, 9:55/0/33/0/9, 10:FF/1/33/0/3, 11:FF/1/CC/1/C, 12:00/0/AA/1/C, 13:FF/1/AA/1/0, 14:FF/0/99/1/F, 15:FF/0/66/0/0, 16:00/0/66/0/F, 17:FF/1/99/1/9, 18:FF/1/FF/1/0.
- R6: For XW > 8, the 8-bit X pattern occupies `vec_x[XW-1:XW-8]`. Each bit below it equals the bit two places above it. For example, 55 becomes 0_1010_1010 at 9 bits and 01_0101_0101 at 10 bits.
- R7: For YW > 8, the 8-bit Y pattern occupies `vec_y[7:0]`, and each bit i ≥ 8 equals base bit i mod 8. For example, CC becomes 00_1100_1100 at 10 bits and 1100_1100_1100 at 12 bits.
- R8: Whenever `vec_valid` is low, `vec_x`, `vec_xm1`, `vec_y`, `vec_ym1`, `vec_e` and `vec_idx` are all 0.
- R9: The set holds 19 vectors for every legal pair of widths (XW ≥ 8, YW ≥ 8), and the `done` timing does not change with width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to play the vector set; taken only when idle |
| vec_valid | output | 1 | High while a vector is being presented |
| vec_x | output | XW | Multiplicand test pattern |
| vec_xm1 | output | 1 | Extra test input below the multiplicand LSB |
| vec_y | output | YW | Multiplier test pattern |
| vec_ym1 | output | 1 | Extra test input below the multiplier LSB |
| vec_e | output | 4 | Test-enable lines, e4 in bit 3 down to e1 in bit 0 |
| vec_idx | output | 5 | Index 0..18 of the vector being presented |
| done | output | 1 | One-cycle pulse after the last vector |

## Verification
The assertions assume that `start` and `rst_n` are synchronous to `clk`. They place no other limit on `start`: it may be high in any cycle, including during a run and in the `done` cycle. The stimulus changes inputs only on the falling edge. It holds `start` high across a whole run to exercise R4, and it drops reset partway through a run. Three instances with widths 8x8, 9x10 and 12x12 share that stimulus, so the period rules for X and Y are exercised on both odd and multiple-of-four extensions.

// File: rtl/tvec_pkg.sv
// Package: shared constants, the base-row record and the base vector table.
// Assumes base patterns are 8 bits wide; wider operands are derived elsewhere.
package tvec_pkg;

    localparam int BASE_W  = 8;
    localparam int NUM_VEC = 19;
    localparam int IDX_W   = $clog2(NUM_VEC);

    typedef struct packed {
        logic [BASE_W-1:0] x;
        logic              xm1;
        logic [BASE_W-1:0] y;
        logic              ym1;
        logic [3:0]        e;
    } base_row_t;

    // Returns the stored 8-bit row for a vector index (zero past the end).
    function automatic base_row_t base_row(input logic [IDX_W-1:0] k);
        base_row_t r;
        case (k)
            5'd0:    r = '{8'h00, 1'b0, 8'h00, 1'b0, 4'h0};
            5'd1:    r = '{8'h80, 1'b0, 8'h55, 1'b0, 4'h0};
            5'd2:    r = '{8'hFF, 1'b1, 8'h55, 1'b0, 4'hF};
            5'd3:    r = '{8'h80, 1'b0, 8'hAA, 1'b1, 4'hF};
            5'd4:    r = '{8'h00, 1'b0, 8'hFF, 1'b0, 4'hC};
            5'd5:    r = '{8'h00, 1'b0, 8'h33, 1'b1, 4'h3};
            5'd6:    r = '{8'hFF, 1'b1, 8'h53, 1'b0, 4'h3};
            5'd7:    r = '{8'hFF, 1'b1, 8'h44, 1'b1, 4'hC};
            5'd8:    r = '{8'h55, 1'b0, 8'hCC, 1'b1, 4'h6};
            5'd9:    r = '{8'h55, 1'b0, 8'h33, 1'b0, 4'h9};
            5'd10:   r = '{8'hFF, 1'b1, 8'h33, 1'b0, 4'h3};
            5'd11:   r = '{8'hFF, 1'b1, 8'hCC, 1'b1, 4'hC};
            5'd12:   r = '{8'h00, 1'b0, 8'hAA, 1'b1, 4'hC};
            5'd13:   r = '{8'hFF, 1'b1, 8'hAA, 1'b1, 4'h0};
            5'd14:   r = '{8'hFF, 1'b0, 8'h99, 1'b1, 4'hF};
            5'd15:   r = '{8'hFF, 1'b0, 8'h66, 1'b0, 4'h0};
            5'd16:   r = '{8'h00, 1'b0, 8'h66, 1'b0, 4'hF};
            5'd17:   r = '{8'hFF, 1'b1, 8'h99, 1'b1, 4'h9};
            5'd18:   r = '{8'hFF, 1'b1, 8'hFF, 1'b1, 4'h0};
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tvec_ctrl.sv
// Module: run controller. Walks an index from 0 to NUM-1, one step per cycle,
// after a start seen while idle, then pulses done once.
// Assumes start and rst_n are synchronous to clk; start is ignored while running.
module tvec_ctrl #(
    parameter int NUM   = 19,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             running,
    output logic [IDX_W-1:0] idx,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM - 1);

    logic at_last;
    assign at_last = running && (idx == LAST);

    // Run flag and index: launch on start when idle, stop after the last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            idx     <= '0;
        end else if (running) begin
            if (at_last) begin
                running <= 1'b0;
                idx     <= '0;
            end else begin
                idx     <= idx + 1'b1;
            end
        end else if (start) begin
            running <= 1'b1;
            idx     <= '0;
        end
    end

    // Done pulse: one cycle, right after the last index was shown.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= at_last;
    end

endmodule

// File: rtl/tvec_rom.sv
// Module: base-row lookup. Maps an index to its stored 8-bit vector row.
// Assumes the index is within 0..NUM_VEC-1; other values give an all-zero row.
module tvec_rom
    import tvec_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output base_row_t        row
);

    // Table lookup, purely combinational.
    always_comb row = base_row(idx);

endmodule

// File: rtl/tvec_stretch.sv
// Module: width stretcher. Widens the 8-bit X pattern toward the LSB with
// period 2, and the 8-bit Y pattern toward the MSB with period 8.
// Assumes XW >= 8 and YW >= 8; pure wiring, no logic depth.
module tvec_stretch
    import tvec_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  base_row_t      row,
    output logic [XW-1:0]  x_wide,
    output logic [YW-1:0]  y_wide
);

    localparam int XPAD = XW - BASE_W;

    if (XW < BASE_W) begin : g_bad_xw
        $error("tvec_stretch: XW must be at least 8");
    end
    if (YW < BASE_W) begin : g_bad_yw
        $error("tvec_stretch: YW must be at least 8");
    end

    // X: stored bits on top, lower bits continue the two-bit period downward.
    for (genvar gi = 0; gi < XW; gi++) begin : g_x
        if (gi >= XPAD) begin : g_keep
            assign x_wide[gi] = row.x[gi - XPAD];
        end else begin : g_ext
            assign x_wide[gi] = row.x[(XPAD - gi) % 2];
        end
    end

    // Y: stored bits at the bottom, upper bits repeat the base pattern upward.
    for (genvar gj = 0; gj < YW; gj++) begin : g_y
        assign y_wide[gj] = row.y[gj % BASE_W];
    end

endmodule

// File: rtl/tvec_sequencer.sv
// Module: top of the test vector sequencer. Plays the 19-vector set once per
// accepted start, widened to XW/YW, and holds every data output at zero when idle.
// Assumes XW >= 8, YW >= 8, and synchronous start/rst_n.
module tvec_sequencer
    import tvec_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             vec_valid,
    output logic [XW-1:0]    vec_x,
    output logic             vec_xm1,
    output logic [YW-1:0]    vec_y,
    output logic             vec_ym1,
    output logic [3:0]       vec_e,
    output logic [IDX_W-1:0] vec_idx,
    output logic             done
);

    logic             running;
    logic [IDX_W-1:0] idx;
    base_row_t        row;
    logic [XW-1:0]    x_wide;
    logic [YW-1:0]    y_wide;

    tvec_ctrl #(.NUM(NUM_VEC), .IDX_W(IDX_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .running (running),
        .idx     (idx),
        .done    (done)
    );

    tvec_rom rom_i (
        .idx (idx),
        .row (row)
    );

    tvec_stretch #(.XW(XW), .YW(YW)) stretch_i (
        .row    (row),
        .x_wide (x_wide),
        .y_wide (y_wide)
    );

    // Output gating: present the vector only while running, zeros otherwise.
    always_comb begin
        vec_valid = running;
        vec_x     = running ? x_wide  : '0;
        vec_xm1   = running ? row.xm1 : 1'b0;
        vec_y     = running ? y_wide  : '0;
        vec_ym1   = running ? row.ym1 : 1'b0;
        vec_e     = running ? row.e   : 4'h0;
        vec_idx   = running ? idx     : '0;
    end

endmodule

// File: rtl/tvec_sequencer_chk.sv
// Checker: timing properties of the sequencer ports, bound into every instance.
// Assumes start and rst_n are synchronous to clk.
module tvec_sequencer_chk
    import tvec_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             vec_valid,
    input logic [XW-1:0]    vec_x,
    input logic             vec_xm1,
    input logic [YW-1:0]    vec_y,
    input logic             vec_ym1,
    input logic [3:0]       vec_e,
    input logic [IDX_W-1:0] vec_idx,
    input logic             done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_VEC - 1);

    // R1: a reset edge leaves the block idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !vec_valid && !done);

    // R2: a start seen while idle launches a run next cycle.
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_valid && start) |=> vec_valid && vec_idx == '0);

    // R2: the index advances by one per cycle until the last vector.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_idx != LAST) |=> vec_valid && vec_idx == $past(vec_idx) + 1'b1);

    // R3: the last vector is followed by done with valid low.
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_idx == LAST) |=> done && !vec_valid);

    // R3: done lasts one cycle.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: start during a run does not restart it.
    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && start && vec_idx != LAST) |=> vec_idx != '0);

    // R8: idle outputs are all zero.
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_x == '0 && !vec_xm1 && vec_y == '0 && !vec_ym1
                        && vec_e == 4'h0 && vec_idx == '0));

endmodule

bind tvec_sequencer tvec_sequencer_chk #(.XW(XW), .YW(YW)) chk_i (.*);

// File: tb/tvec_sequencer_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with three width variants each cycle.
module tvec_sequencer_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    // DUT outputs: 8x8, 9x10, 12x12
    logic v0, v1, v2, xm0, xm1_1, xm2, ym0, ym1_1, ym2, d0, d1, d2;
    logic [7:0]  x0;  logic [7:0]  y0;
    logic [8:0]  x1;  logic [9:0]  y1;
    logic [11:0] x2;  logic [11:0] y2;
    logic [3:0]  e0, e1, e2;
    logic [4:0]  i0, i1, i2;

    tvec_sequencer #(.XW(8), .YW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_valid(v0), .vec_x(x0),
        .vec_xm1(xm0), .vec_y(y0), .vec_ym1(ym0), .vec_e(e0), .vec_idx(i0), .done(d0));
    tvec_sequencer #(.XW(9), .YW(10)) dut_a (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_valid(v1), .vec_x(x1),
        .vec_xm1(xm1_1), .vec_y(y1), .vec_ym1(ym1_1), .vec_e(e1), .vec_idx(i1), .done(d1));
    tvec_sequencer #(.XW(12), .YW(12)) dut_b (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_valid(v2), .vec_x(x2),
        .vec_xm1(xm2), .vec_y(y2), .vec_ym1(ym2), .vec_e(e2), .vec_idx(i2), .done(d2));

    // Reference vector set (R5), written as one row per index.
    logic [7:0] rx [19] = '{8'h00,8'h80,8'hFF,8'h80,8'h00,8'h00,8'hFF,8'hFF,8'h55,8'h55,
                            8'hFF,8'hFF,8'h00,8'hFF,8'hFF,8'hFF,8'h00,8'hFF,8'hFF};
    logic       rxm[19] = '{0,0,1,0,0,0,1,1,0,0,1,1,0,1,0,0,0,1,1};
    logic [7:0] ry [19] = '{8'h00,8'h55,8'h55,8'hAA,8'hFF,8'h33,8'h53,8'h44,8'hCC,8'h33,
                            8'h33,8'hCC,8'hAA,8'hAA,8'h99,8'h66,8'h66,8'h99,8'hFF};
    logic       rym[19] = '{0,0,0,1,0,1,0,1,1,0,0,1,1,1,1,0,0,1,1};
    logic [3:0] re [19] = '{4'h0,4'h0,4'hF,4'hF,4'hC,4'h3,4'h3,4'hC,4'h6,4'h9,
                            4'h3,4'hC,4'hC,4'h0,4'hF,4'h0,4'hF,4'h9,4'h0};

    // R6: grow X one bit at a time on the right, copying the bit two places up.
    function automatic logic [63:0] grow_x(input logic [7:0] b, input int w);
        logic [63:0] v = 64'(b);
        for (int n = 8; n < w; n++) v = (v << 1) | ((v >> 1) & 64'd1);
        return v;
    endfunction

    // R7: grow Y on the left by repeating the base pattern.
    function automatic logic [63:0] grow_y(input logic [7:0] b, input int w);
        logic [63:0] v = 64'(b);
        for (int n = 8; n < w; n++) v[n] = b[n % 8];
        return v;
    endfunction

    // Reference model state, stepped on each rising edge.
    bit m_run = 0, m_done = 0;
    int m_idx = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 0; m_idx <= 0; m_done <= 0;
        end else begin
            m_done <= m_run && (m_idx == 18);
            if (m_run) begin
                if (m_idx == 18) begin m_run <= 0; m_idx <= 0; end
                else m_idx <= m_idx + 1;
            end else if (start) begin
                m_run <= 1; m_idx <= 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic chk_dut(input string nm, input int xw, input int yw, input logic v,
                           input logic [63:0] x, input logic xm, input logic [63:0] y,
                           input logic ym, input logic [3:0] e, input logic [4:0] ix,
                           input logic d);
        logic [63:0] ex = 0, ey = 0;
        logic exm = 0, eym = 0;
        logic [3:0] ee = 0;
        int ei = 0;
        if (m_run) begin
            ex = grow_x(rx[m_idx], xw); ey = grow_y(ry[m_idx], yw);
            exm = rxm[m_idx]; eym = rym[m_idx]; ee = re[m_idx]; ei = m_idx;
        end
        chk({nm, " R1/R2 valid"}, 64'(v), 64'(m_run));
        chk({nm, " R2/R4 index"}, 64'(ix), 64'(ei));
        chk({nm, " R3 done"}, 64'(d), 64'(m_done));
        chk({nm, " R5/R6/R8 X"}, x, ex);
        chk({nm, " R5/R8 x-1"}, 64'(xm), 64'(exm));
        chk({nm, " R5/R7/R8 Y"}, y, ey);
        chk({nm, " R5/R8 y-1"}, 64'(ym), 64'(eym));
        chk({nm, " R5/R8 E"}, 64'(e), 64'(ee));
    endtask

    // Compare all three instances against the model mid-cycle.
    always @(negedge clk) if (cmp_on) begin
        chk_dut("8x8",   8,  8, v0, 64'(x0), xm0,   64'(y0), ym0,   e0, i0, d0);
        chk_dut("9x10",  9, 10, v1, 64'(x1), xm1_1, 64'(y1), ym1_1, e1, i1, d1);
        chk_dut("12x12", 12, 12, v2, 64'(x2), xm2,   64'(y2), ym2,   e2, i2, d2);
    end

    // R9: count valid cycles per run on the widest instance.
    int vcount = 0;
    always @(negedge clk) if (cmp_on) begin
        if (v2) vcount++;
        if (d2) begin
            n_cmp++;
            if (vcount != 19) begin
                n_bad++;
                $display("FAIL R9 vector count: actual %0d expected 19", vcount);
            end
            vcount = 0;
        end
        if (!rst_n) vcount = 0;
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stimulus: reset, plain run, start held through a run, mid-run reset, rerun.
    initial begin
        wait_cycles(3);
        cmp_on = 1'b1;               // R1: reset state compared here
        wait_cycles(1);
        rst_n = 1'b1;
        wait_cycles(2);
        start = 1'b1; wait_cycles(1); start = 1'b0;   // R2 plain run
        wait_cycles(24);
        start = 1'b1; wait_cycles(45); start = 1'b0;  // R4: held high, restart at done
        wait_cycles(5);
        start = 1'b1; wait_cycles(1); start = 1'b0;
        wait_cycles(7);
        rst_n = 1'b0; wait_cycles(2); rst_n = 1'b1;   // R1 mid-run reset
        wait_cycles(3);
        start = 1'b1; wait_cycles(1); start = 1'b0;   // R9 full run after reset
        wait_cycles(25);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule